// File: doc/BRIEF.md
# Byte-command I2C master

This block is an I2C bus master that software steers one bus primitive at a time through two 32-bit Wishbone registers. A write to the command register names an operation in its top byte: a START condition, a transmitted byte, a received byte, or a STOP condition. The block then runs that primitive on the open-drain SCL and SDA lines. Software polls the status register until the busy field clears, then reads the acknowledge result or the captured byte.

A full transaction is a sequence of such commands. Software issues START, sends the target address byte ((7-bit address << 1) | R/W, with R/W = 1 for a read), sends or receives the data bytes, and issues STOP. Each bit period lasts `BIT_CYCLES` system clocks and is split into four equal quarters. The master never waits on a target holding SCL low and never arbitrates against another master.

Top module: `i2c_byte_master`

## Requirements
- R1: After synchronous reset both line enables `scl_oe_o` and `sda_oe_o` are 0 (lines released), and the status and command registers read 0.
- R2: `wb_ack_o` is high in exactly the cycles where `wb_cyc_i` and `wb_stb_i` are both high. Address 0 reads back the last accepted command word. Address 1 reads the status word.
- R3: Command code 0x01 in bits [31:24] produces a START: SDA falls while SCL is high. At completion SCL and SDA are both held low.
- R4: Command code 0x02 sends bits [7:0] most significant bit first, one bit per SCL high pulse. An address byte formed as (address << 1) | R/W goes out unchanged.
- R5: After a transmit, status bit 8 is 1 if SDA was high (no acknowledge) during the ninth SCL pulse, and 0 if the target pulled it low.
- R6: Command code 0x03 receives eight bits MSB first into status bits [7:0]. On the ninth pulse the master drives SDA low (acknowledge) when command bit 0 is 0, and leaves it high (no acknowledge) when command bit 0 is 1.
- R7: Command code 0x04 produces a STOP: SDA rises while SCL is high. At completion both lines are released.
- R8: While a command runs, status bits [31:24] hold its nonzero command code. They read 0x00 once it has finished.
- R9: A command-register write made while busy is ignored: the running command is unaffected and the command register keeps its earlier value.
- R10: During transmit and receive, SDA changes only while SCL is low. SDA is sampled at the middle of the SCL high time.
- R11: Successive SCL rising edges within a byte are exactly `BIT_CYCLES` clock cycles apart.
- R12: A command code other than 0x01 to 0x04 starts nothing: busy stays 0 and both lines keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | 1 | Register select: 0 command, 1 status |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
Two events can land in the same clock: a host command write and the engine's own progress through a running command, such as a quarter tick or the final tick that clears busy. The bench provokes this by writing a second transmit command partway through a byte. It then judges the result at the pins and the registers: the byte seen on the wire must be the first one, and the command register must still hold the first word. The bench's own model of a target sweeps all 256 byte values in both directions. It also watches every SDA edge against SCL, which separates legal START and STOP edges from illegal data changes.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;

  localparam logic [7:0] OP_START = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_STOP  = 8'h04;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } drive_t;

  function automatic logic op_is_valid(input logic [7:0] op);
    return (op == OP_START) || (op == OP_WRITE) || (op == OP_READ) || (op == OP_STOP);
  endfunction

  function automatic logic op_is_byte(input logic [7:0] op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  // index of the final bit slot of a command
  function automatic logic [3:0] last_slot(input logic [7:0] op);
    return op_is_byte(op) ? 4'd8 : 4'd0;
  endfunction

  // line drive for one quarter of one bit slot
  function automatic drive_t quarter_drive(input logic [7:0] op, input logic [3:0] slot,
                                           input logic [1:0] ph, input logic [7:0] tx,
                                           input logic last);
    drive_t d;
    d.scl_low = (ph == 2'd0) || (ph == 2'd3);
    d.sda_low = 1'b0;
    case (op)
      OP_START: d.sda_low = (ph >= 2'd2);
      OP_STOP: begin
        d.scl_low = (ph == 2'd0);
        d.sda_low = (ph <= 2'd1);
      end
      OP_WRITE: d.sda_low = (slot < 4'd8) ? ~tx[3'd7 - slot[2:0]] : 1'b0;
      OP_READ:  d.sda_low = (slot == 4'd8) ? ~last : 1'b0;
      default:  d.scl_low = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic [31:0] status_word(input logic busy, input logic [7:0] op,
                                              input logic nack, input logic [7:0] rx);
    return {(busy ? op : 8'h00), 15'h0000, nack, rx};
  endfunction

endpackage

// File: rtl/i2cbm_qtimer.sv
module i2cbm_qtimer #(
  parameter int QUARTER = 64,
  localparam int QW = (QUARTER > 1) ? $clog2(QUARTER) : 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic tick_o
);
  logic [QW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == QW'(QUARTER - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i || tick_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2cbm_wb_regs.sv
module i2cbm_wb_regs
  import i2cbm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic        wb_adr_i,
  input  logic [31:0] wb_dat_i,
  output logic [31:0] wb_dat_o,
  output logic        wb_ack_o,
  input  logic        busy_i,
  input  logic [31:0] status_i,
  output logic        go_o,
  output logic [7:0]  op_o,
  output logic [7:0]  tx_o
);
  logic [31:0] ctrl_q;
  logic        wr_ctrl_w;

  assign wb_ack_o  = wb_cyc_i && wb_stb_i;
  assign wr_ctrl_w = wb_ack_o && wb_we_i && !wb_adr_i;
  assign wb_dat_o  = wb_adr_i ? status_i : ctrl_q;
  assign go_o      = wr_ctrl_w && !busy_i && op_is_valid(wb_dat_i[31:24]);
  assign op_o      = wb_dat_i[31:24];
  assign tx_o      = wb_dat_i[7:0];

  always_ff @(posedge clk_i) begin
    if (rst_i)                    ctrl_q <= '0;
    else if (wr_ctrl_w && !busy_i) ctrl_q <= wb_dat_i;
  end
endmodule

// File: rtl/i2cbm_engine.sv
module i2cbm_engine
  import i2cbm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       go_i,
  input  logic [7:0] op_i,
  input  logic [7:0] tx_i,
  input  logic       tick_i,
  input  logic       sda_i,
  output logic       busy_o,
  output logic [7:0] op_o,
  output logic       nack_o,
  output logic [7:0] rx_o,
  output logic       scl_low_o,
  output logic       sda_low_o
);
  logic       busy_q, nack_q, scl_low_q, sda_low_q;
  logic [7:0] op_q, tx_q, sh_q, rx_q;
  logic [3:0] slot_q, nxt_slot_w;
  logic [1:0] ph_q, nxt_ph_w;
  logic       final_quarter_w, sample_w;
  drive_t     nxt_drive_w, go_drive_w;

  assign final_quarter_w = (slot_q == last_slot(op_q)) && (ph_q == 2'd3);
  assign sample_w        = busy_q && tick_i && (ph_q == 2'd1);
  assign nxt_ph_w        = ph_q + 2'd1;
  assign nxt_slot_w      = (ph_q == 2'd3) ? slot_q + 4'd1 : slot_q;
  assign nxt_drive_w     = quarter_drive(op_q, nxt_slot_w, nxt_ph_w, tx_q, tx_q[0]);
  assign go_drive_w      = quarter_drive(op_i, 4'd0, 2'd0, tx_i, tx_i[0]);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q <= 1'b0; op_q <= '0; tx_q <= '0; sh_q <= '0; rx_q <= '0;
      nack_q <= 1'b0; slot_q <= '0; ph_q <= '0;
      scl_low_q <= 1'b0; sda_low_q <= 1'b0;
    end else if (go_i) begin
      busy_q    <= 1'b1;
      op_q      <= op_i;
      tx_q      <= tx_i;
      slot_q    <= '0;
      ph_q      <= '0;
      scl_low_q <= go_drive_w.scl_low;
      sda_low_q <= go_drive_w.sda_low;
    end else if (busy_q && tick_i) begin
      if (sample_w) begin
        if (slot_q < 4'd8) sh_q <= {sh_q[6:0], sda_i};
        if (op_q == OP_READ && slot_q == 4'd7) rx_q <= {sh_q[6:0], sda_i};
        if (op_q == OP_WRITE && slot_q == 4'd8) nack_q <= sda_i;
      end
      if (final_quarter_w) begin
        busy_q <= 1'b0;
      end else begin
        slot_q    <= nxt_slot_w;
        ph_q      <= nxt_ph_w;
        scl_low_q <= nxt_drive_w.scl_low;
        sda_low_q <= nxt_drive_w.sda_low;
      end
    end
  end

  assign busy_o    = busy_q;
  assign op_o      = op_q;
  assign nack_o    = nack_q;
  assign rx_o      = rx_q;
  assign scl_low_o = scl_low_q;
  assign sda_low_o = sda_low_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cbm_pkg::*;
#(
  parameter int BIT_CYCLES = 256,
  localparam int QUARTER = BIT_CYCLES / 4
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        wb_cyc_i,
  input  logic        wb_stb_i,
  input  logic        wb_we_i,
  input  logic        wb_adr_i,
  input  logic [31:0] wb_dat_i,
  output logic [31:0] wb_dat_o,
  output logic        wb_ack_o,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  input  logic        sda_i
);
  logic        go_w, busy_w, tick_w, nack_w;
  logic [7:0]  go_op_w, go_tx_w, op_w, rx_w;
  logic [31:0] status_w;

  assign status_w = status_word(busy_w, op_w, nack_w, rx_w);

  i2cbm_wb_regs u_regs (
    .clk_i(clk_i), .rst_i(rst_i),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i),
    .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
    .busy_i(busy_w), .status_i(status_w),
    .go_o(go_w), .op_o(go_op_w), .tx_o(go_tx_w)
  );

  i2cbm_qtimer #(.QUARTER(QUARTER)) u_qtimer (
    .clk_i(clk_i), .rst_i(rst_i), .run_i(busy_w), .tick_o(tick_w)
  );

  i2cbm_engine u_engine (
    .clk_i(clk_i), .rst_i(rst_i),
    .go_i(go_w), .op_i(go_op_w), .tx_i(go_tx_w),
    .tick_i(tick_w), .sda_i(sda_i),
    .busy_o(busy_w), .op_o(op_w), .nack_o(nack_w), .rx_o(rx_w),
    .scl_low_o(scl_oe_o), .sda_low_o(sda_oe_o)
  );
endmodule

// File: rtl/i2cbm_checker.sv
module i2cbm_checker
  import i2cbm_pkg::*;
#(
  parameter int QUARTER = 64
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       go_i,
  input logic       busy_i,
  input logic       tick_i,
  input logic [7:0] op_i,
  input logic       scl_oe_i,
  input logic       sda_oe_i
);
  int unsigned qc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !busy_i || tick_i) qc_q <= 0;
    else                            qc_q <= qc_q + 1;
  end

  AST_BUSY_FROM_GO: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_i) |-> $past(go_i)); // R8

  AST_OP_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_i && !tick_i) |=> (op_i == $past(op_i))); // R9

  AST_SDA_QUIET_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_i && op_is_byte(op_i) && !scl_oe_i && !$past(scl_oe_i)) |-> $stable(sda_oe_i)); // R10

  AST_TICK_ON_TIME: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |-> (busy_i && qc_q == QUARTER - 1)); // R11

  AST_TICK_NOT_LATE: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_i && qc_q == QUARTER - 1) |-> tick_i); // R11

  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(busy_i) && op_i == OP_STOP) |-> (!scl_oe_i && !sda_oe_i)); // R7

  AST_START_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(busy_i) && op_i == OP_START) |-> (scl_oe_i && sda_oe_i)); // R3
endmodule

bind i2c_byte_master i2cbm_checker #(.QUARTER(QUARTER)) u_checker (
  .clk_i(clk_i), .rst_i(rst_i), .go_i(go_w), .busy_i(busy_w), .tick_i(tick_w),
  .op_i(op_w), .scl_oe_i(scl_oe_o), .sda_oe_i(sda_oe_o)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
  localparam int BIT_CYCLES = 8;
  localparam real TCLK = 5.0;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0, adr = 1'b0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic ack, scl_oe, sda_oe;
  logic tgt_low = 1'b0;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | tgt_low);

  int checks = 0, errors = 0, starts = 0, stops = 0, viol = 0;
  bit in_byte = 1'b0;

  always #2.5 clk = ~clk;

  i2c_byte_master #(.BIT_CYCLES(BIT_CYCLES)) u_i2c_byte_master (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .sda_i(sda_line)
  );

  // R10: SDA edges with SCL high are only legal as START/STOP
  always @(negedge sda_line) if (scl_line === 1'b1) begin
    if (in_byte) viol++; else starts++;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    if (in_byte) viol++; else stops++;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wb_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    @(negedge clk);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic wb_read(input logic a, output logic [31:0] d, output logic k);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a;
    #1 d = rdat; k = ack;
    @(negedge clk);
    cyc = 0; stb = 0;
  endtask

  task automatic poll_idle(output logic [31:0] s);
    logic k;
    for (int n = 0; n < 500; n++) begin
      wb_read(1'b1, s, k);
      if (s[31:24] == 8'h00) return;
    end
    chk(1'b0, "R8 busy never cleared", s, 32'h0);
  endtask

  task automatic simple_cmd(input logic [31:0] w);
    logic [31:0] s;
    wb_write(1'b0, w);
    poll_idle(s);
  endtask

  task automatic tx_byte(input logic [7:0] b, input bit tack,
                         output logic [7:0] got, output logic [31:0] s, output real per);
    real t0;
    in_byte = 1;
    got = '0; per = 0.0; t0 = 0.0;
    fork
      begin
        for (int i = 0; i < 8; i++) begin
          @(posedge scl_line);
          got = {got[6:0], sda_line};
          if (i == 0) t0 = $realtime;
          if (i == 1) per = $realtime - t0;
          @(negedge scl_line);
        end
        tgt_low = tack;
        @(posedge scl_line);
        @(negedge scl_line);
        tgt_low = 0;
      end
      begin
        wb_write(1'b0, {8'h02, 16'h0000, b});
        poll_idle(s);
      end
    join
    in_byte = 0;
  endtask

  task automatic rx_byte(input logic [7:0] b, input bit last,
                         output logic [31:0] s, output logic mack);
    in_byte = 1;
    mack = 1'bx;
    fork
      begin
        for (int i = 7; i >= 0; i--) begin
          tgt_low = ~b[i];
          @(posedge scl_line);
          @(negedge scl_line);
        end
        tgt_low = 0;
        @(posedge scl_line);
        mack = sda_line;
        @(negedge scl_line);
      end
      begin
        wb_write(1'b0, {8'h03, 23'h0, last});
        poll_idle(s);
      end
    join
    in_byte = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic k, mack;
    logic [7:0] got;
    real per;
    int s0;

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {30'h0, scl_oe, sda_oe}, 32'h0);
    wb_read(1'b1, s, k);
    chk(s == 32'h0, "R1 status zero", s, 32'h0);
    wb_read(1'b0, s, k);
    chk(s == 32'h0, "R1 command zero", s, 32'h0);

    // R2 ack only with cyc and stb
    @(negedge clk); stb = 1; cyc = 0;
    #1 chk(ack == 1'b0, "R2 ack without cyc", {31'h0, ack}, 32'h0);
    @(negedge clk); stb = 0;
    wb_read(1'b1, s, k);
    chk(k == 1'b1, "R2 ack on access", {31'h0, k}, 32'h1);

    // R12 invalid codes start nothing; R2 readback
    wb_write(1'b0, 32'h0000_1234);
    wb_read(1'b0, s, k);
    chk(s == 32'h0000_1234, "R2 command readback", s, 32'h0000_1234);
    wb_read(1'b1, s, k);
    chk(s[31:24] == 8'h00, "R12 code 0x00 idle", s, 32'h0);
    wb_write(1'b0, 32'h0700_0000);
    wb_read(1'b1, s, k);
    chk(s[31:24] == 8'h00, "R12 code 0x07 idle", s, 32'h0);
    chk(scl_oe == 0 && sda_oe == 0, "R12 lines unchanged", {30'h0, scl_oe, sda_oe}, 32'h0);

    // R3 START, R8 busy field
    s0 = starts;
    wb_write(1'b0, 32'h0100_0000);
    wb_read(1'b1, s, k);
    chk(s[31:24] == 8'h01, "R8 busy field during START", s, 32'h0100_0000);
    poll_idle(s);
    chk(s[31:24] == 8'h00, "R8 busy field cleared", s, 32'h0);
    chk(starts == s0 + 1, "R3 START edge", starts, s0 + 1);
    chk(scl_oe && sda_oe, "R3 lines held low", {30'h0, scl_oe, sda_oe}, 32'h3);

    // R4 address byte, read direction
    tx_byte(8'hA1, 1'b1, got, s, per);
    chk(got == 8'hA1, "R4 address byte", got, 8'hA1);
    chk(s[8] == 1'b0, "R5 acked address", s[8], 1'b0);

    // R4 R5 R11 sweep of every byte value
    for (int b = 0; b < 256; b++) begin
      tx_byte(8'(b), b[0], got, s, per);
      chk(got == 8'(b), "R4 transmitted byte", got, 8'(b));
      chk(s[8] == !b[0], "R5 nack flag", s[8], !b[0]);
      chk(per == BIT_CYCLES * TCLK, "R11 bit period", int'(per), BIT_CYCLES * 5);
    end

    // R9 write while busy is ignored
    in_byte = 1;
    got = '0;
    fork
      begin
        for (int i = 0; i < 8; i++) begin
          @(posedge scl_line); got = {got[6:0], sda_line}; @(negedge scl_line);
        end
        tgt_low = 1; @(posedge scl_line); @(negedge scl_line); tgt_low = 0;
      end
      begin
        wb_write(1'b0, 32'h0200_00A5);
        repeat (10) @(negedge clk);
        wb_write(1'b0, 32'h0200_00C3);
        poll_idle(s);
      end
    join
    in_byte = 0;
    chk(got == 8'hA5, "R9 first byte kept", got, 8'hA5);
    wb_read(1'b0, s, k);
    chk(s == 32'h0200_00A5, "R9 command unchanged", s, 32'h0200_00A5);
    wb_read(1'b1, s, k);
    chk(s[31:24] == 8'h00, "R9 no second command", s, 32'h0);

    // R7 STOP
    s0 = stops;
    simple_cmd(32'h0400_0000);
    chk(stops == s0 + 1, "R7 STOP edge", stops, s0 + 1);
    chk(!scl_oe && !sda_oe, "R7 lines released", {30'h0, scl_oe, sda_oe}, 32'h0);

    // R6 receive sweep
    simple_cmd(32'h0100_0000);
    tx_byte(8'hA1, 1'b1, got, s, per);
    for (int b = 0; b < 256; b++) begin
      rx_byte(8'(b), (b % 4) == 3, s, mack);
      chk(s[7:0] == 8'(b), "R6 received byte", s[7:0], 8'(b));
      chk(mack == ((b % 4) == 3), "R6 master ack bit", mack, ((b % 4) == 3));
    end
    simple_cmd(32'h0400_0000);
    chk(!scl_oe && !sda_oe, "R7 released after read", {30'h0, scl_oe, sda_oe}, 32'h0);

    chk(viol == 0, "R10 SDA changed with SCL high", viol, 0);

    summary();
    $finish;
  end
endmodule